// File: doc/BRIEF.md
# Up/Down Timer Counter Core

This block is the counting heart of a general-purpose timer. A prescaler divides the clock and produces count ticks. A counter steps on each tick against an auto-reload limit, and a single compare value drives a channel flag. The prescaler divisor, the auto-reload limit and the compare value each have a preload copy that software writes. The working copy takes the preload value only when an update event occurs.

The counter can run edge-aligned, counting up or down, or in one of three center-aligned modes. In the center-aligned modes it climbs to the limit and falls back to zero, and the hardware owns the direction bit. An update event can come from three places: a software strobe, a wrap of the counter, or a strobe from an external slave controller. Two control bits decide what happens with these events. One bit suppresses update events altogether. The other limits the update request output to counter wraps only.

In single-pulse operation the enable clears itself at the next update event. An external strobe can set the enable at any time.

Top module: `updown_timer`

## Requirements
- R1: After reset, count is 0, enable is 0, direction is 0 (up), alignment is 00, and the update request and compare flag outputs are low.
- R2: While enabled, the counter takes one step every PSC+1 clocks, where PSC is the active prescaler value. While disabled, neither the counter nor the prescaler moves.
- R3: In edge-aligned mode counting up (direction 0), the counter wraps from the active limit to 0. That tick is an overflow, which produces an update event and, if updates are allowed, an update request pulse.
- R4: In edge-aligned mode counting down (direction 1), a tick at 0 reloads the counter with the limit. That tick is an underflow and an update event, and the reload uses the newly loaded limit.
- R5: Alignment encodings are 00 edge, 01 center with down-only flags, 10 center with up-only flags, and 11 center with flags in both directions. In a center mode the counter runs up to the limit, turns to direction 1 at limit-1 (an overflow), runs down, and turns to direction 0 when it steps from 1 to 0 (an underflow). In these modes a software write to the direction bit is ignored.
- R6: The compare flag pulses for one cycle after a tick that brings the count equal to the active compare value. Mode 01 allows this only on downward steps, mode 10 only on upward steps, and modes 00 and 11 on steps in either direction.
- R7: While the enable is 1 and the alignment is 00, a control write that sets a non-zero alignment leaves the alignment at 00. The other fields of that write still take effect.
- R8: With the single-pulse bit set, the enable clears at the next update event, and the counter stops at the value that event gives it.
- R9: With the update-source bit at 0, every update event (software strobe, wrap, or slave update) pulses the request. With it at 1, only a wrap pulses the request.
- R10: With the update-disable bit at 1, no request is raised and the working copies keep their values. A software or slave update strobe still restarts the counter and the prescaler.
- R11: Preload writes do not reach the working copies until an update event. A software update restarts the count at 0 when the direction is 0, and at the new limit when the direction is 1.
- R12: A slave enable strobe sets the enable bit. A slave update strobe behaves exactly like the software update strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the control fields |
| cfg_en | input | 1 | Enable value written |
| cfg_dir | input | 1 | Direction value written (0 up, 1 down) |
| cfg_onepulse | input | 1 | Single-pulse mode value written |
| cfg_src_ovf_only | input | 1 | Update-source value written (1: only wraps raise a request) |
| cfg_upd_off | input | 1 | Update-disable value written |
| cfg_align | input | 2 | Alignment mode value written |
| psc_we | input | 1 | Prescaler preload write strobe |
| psc_wdata | input | PSC_W | Prescaler preload value |
| arr_we | input | 1 | Limit preload write strobe |
| arr_wdata | input | CNT_W | Limit preload value |
| cmp_we | input | 1 | Compare preload write strobe |
| cmp_wdata | input | CNT_W | Compare preload value |
| sw_update | input | 1 | Software update-generate strobe |
| slv_update | input | 1 | Slave controller update/restart strobe |
| slv_enable | input | 1 | Slave controller enable strobe |
| cnt_en | output | 1 | Current enable bit |
| cnt_dir | output | 1 | Current direction bit |
| cnt_align | output | 2 | Current alignment mode |
| count | output | CNT_W | Counter value |
| upd_req | output | 1 | Update interrupt/DMA request pulse |
| cmp_flag | output | 1 | Channel compare flag pulse |

## Verification
The bench builds the block with CNT_W=8 and PSC_W=4. These widths keep limits of three or four counts practical, so every wrap, direction turn and single-pulse stop happens many times within a few hundred cycles. The prescaler width still allows divide-by-three runs to show the tick spacing. The reset limit of 255 then shows that nothing reaches the working copies before the first update.

// File: rtl/updt_pkg.sv
package updt_pkg;
  typedef enum logic [1:0] {
    ALN_EDGE     = 2'b00,
    ALN_CTR_DN   = 2'b01,
    ALN_CTR_UP   = 2'b10,
    ALN_CTR_BOTH = 2'b11
  } align_e;
endpackage

// File: rtl/timer_rst_sync.sv
module timer_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_n_o = s2_q;
endmodule

// File: rtl/timer_prescaler.sv
module timer_prescaler #(
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [PSC_W-1:0] div,
  output logic             tick
);
  logic [PSC_W-1:0] cnt_q, cnt_n;
  logic             cnt_ce;

  always_comb begin
    tick   = run && !restart && (cnt_q >= div);
    cnt_ce = restart || run;
    if (restart || tick) cnt_n = '0;
    else                 cnt_n = cnt_q + PSC_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_n;
  end
endmodule

// File: rtl/timer_shadow_bank.sv
module timer_shadow_bank #(
  parameter int             CNT_W   = 16,
  parameter int             PSC_W   = 16,
  parameter logic [CNT_W-1:0] ARR_RST = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             psc_we,
  input  logic [PSC_W-1:0] psc_wdata,
  input  logic             arr_we,
  input  logic [CNT_W-1:0] arr_wdata,
  input  logic             cmp_we,
  input  logic [CNT_W-1:0] cmp_wdata,
  output logic [PSC_W-1:0] psc_act,
  output logic [CNT_W-1:0] arr_act,
  output logic [CNT_W-1:0] arr_nxt,
  output logic [CNT_W-1:0] cmp_act
);
  logic [PSC_W-1:0] psc_pre;
  logic [CNT_W-1:0] arr_pre, cmp_pre;

  // preload copies: software side
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_pre <= '0;
      arr_pre <= ARR_RST;
      cmp_pre <= '0;
    end else begin
      if (psc_we) psc_pre <= psc_wdata;
      if (arr_we) arr_pre <= arr_wdata;
      if (cmp_we) cmp_pre <= cmp_wdata;
    end
  end

  // working copies: loaded only by an update event
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_act <= '0;
      arr_act <= ARR_RST;
      cmp_act <= '0;
    end else if (load) begin
      psc_act <= psc_pre;
      arr_act <= arr_pre;
      cmp_act <= cmp_pre;
    end
  end

  assign arr_nxt = load ? arr_pre : arr_act;
endmodule

// File: rtl/timer_count_core.sv
module timer_count_core
  import updt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             restart,
  input  logic             dir_wr,
  input  logic             dir_wval,
  input  align_e           align,
  input  logic [CNT_W-1:0] arr_act,
  input  logic [CNT_W-1:0] arr_nxt,
  input  logic [CNT_W-1:0] cmp_act,
  output logic [CNT_W-1:0] count,
  output logic             dir,
  output logic             wrap,
  output logic             cmp_flag
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             dir_q, dir_n, hit_q, hit_n;
  logic             center, top_hit, bot_hit, move_down, allow;

  always_comb begin
    center    = (align != ALN_EDGE);
    top_hit   = (cnt_q >= arr_act);
    bot_hit   = center ? (cnt_q <= ONE) : (cnt_q == '0);
    wrap      = tick && (dir_q ? bot_hit : top_hit);
    move_down = dir_q || (center && wrap);
    cnt_n     = cnt_q;
    dir_n     = dir_q;
    if (restart) begin
      cnt_n = dir_q ? arr_nxt : '0;
    end else if (tick) begin
      if (!dir_q) begin
        if (!top_hit)    cnt_n = cnt_q + ONE;
        else if (center) cnt_n = (arr_act == '0) ? '0 : arr_act - ONE;
        else             cnt_n = '0;
      end else begin
        if (!bot_hit)    cnt_n = cnt_q - ONE;
        else             cnt_n = center ? '0 : arr_nxt;
      end
      if (center && wrap) dir_n = !dir_q;
    end
    if (dir_wr) dir_n = dir_wval;
    unique case (align)
      ALN_CTR_DN: allow = move_down;
      ALN_CTR_UP: allow = !move_down;
      default:    allow = 1'b1;
    endcase
    hit_n = tick && !restart && allow && (cnt_n == cmp_act);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dir_q <= 1'b0;
      hit_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      dir_q <= dir_n;
      hit_q <= hit_n;
    end
  end

  assign count    = cnt_q;
  assign dir      = dir_q;
  assign cmp_flag = hit_q;

  // R2: without a tick or restart the count holds
  a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !restart) |=> (cnt_q == $past(cnt_q)));

  // R6: mode 10 flags only follow an upward step
  a_r6_up_only: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_q && $past(align) == ALN_CTR_UP) |->
      ({1'b0, cnt_q} == {1'b0, $past(cnt_q)} + (CNT_W+1)'(1)));

  // R6: mode 01 flags never follow an upward step
  a_r6_down_only: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_q && $past(align) == ALN_CTR_DN) |->
      ({1'b0, cnt_q} != {1'b0, $past(cnt_q)} + (CNT_W+1)'(1)));
endmodule

// File: rtl/updown_timer.sv
module updown_timer
  import updt_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_en,
  input  logic             cfg_dir,
  input  logic             cfg_onepulse,
  input  logic             cfg_src_ovf_only,
  input  logic             cfg_upd_off,
  input  logic [1:0]       cfg_align,
  input  logic             psc_we,
  input  logic [PSC_W-1:0] psc_wdata,
  input  logic             arr_we,
  input  logic [CNT_W-1:0] arr_wdata,
  input  logic             cmp_we,
  input  logic [CNT_W-1:0] cmp_wdata,
  input  logic             sw_update,
  input  logic             slv_update,
  input  logic             slv_enable,
  output logic             cnt_en,
  output logic             cnt_dir,
  output logic [1:0]       cnt_align,
  output logic [CNT_W-1:0] count,
  output logic             upd_req,
  output logic             cmp_flag
);
  localparam logic [CNT_W-1:0] ARR_RST = '1;

  logic             rst_s;
  logic             en_q, en_n, op_q, op_n, src_q, src_n, off_q, off_n;
  logic             req_q, req_n;
  align_e           align_q, align_n, align_w;
  logic             restart, tick, wrap, evt, dir_wr;
  logic [PSC_W-1:0] psc_act;
  logic [CNT_W-1:0] arr_act, arr_nxt, cmp_act;

  timer_rst_sync u_rst (.clk(clk), .rst_n_i(rst_n), .rst_n_o(rst_s));

  assign restart = sw_update | slv_update;
  assign evt     = !off_q && (wrap || restart);
  assign align_w = align_e'(cfg_align);

  always_comb begin
    en_n    = en_q;
    op_n    = op_q;
    src_n   = src_q;
    off_n   = off_q;
    align_n = align_q;
    if (cfg_we) begin
      en_n  = cfg_en;
      op_n  = cfg_onepulse;
      src_n = cfg_src_ovf_only;
      off_n = cfg_upd_off;
      if (!(en_q && align_q == ALN_EDGE && align_w != ALN_EDGE))
        align_n = align_w;
    end
    if (slv_enable)  en_n = 1'b1;
    if (op_q && evt) en_n = 1'b0;
    dir_wr = cfg_we && (align_n == ALN_EDGE);
    req_n  = evt && (!src_q || wrap);
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      en_q    <= 1'b0;
      op_q    <= 1'b0;
      src_q   <= 1'b0;
      off_q   <= 1'b0;
      align_q <= ALN_EDGE;
      req_q   <= 1'b0;
    end else begin
      en_q    <= en_n;
      op_q    <= op_n;
      src_q   <= src_n;
      off_q   <= off_n;
      align_q <= align_n;
      req_q   <= req_n;
    end
  end

  timer_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst_n(rst_s), .run(en_q), .restart(restart),
    .div(psc_act), .tick(tick)
  );

  timer_shadow_bank #(.CNT_W(CNT_W), .PSC_W(PSC_W), .ARR_RST(ARR_RST)) u_shadow (
    .clk(clk), .rst_n(rst_s), .load(evt),
    .psc_we(psc_we), .psc_wdata(psc_wdata),
    .arr_we(arr_we), .arr_wdata(arr_wdata),
    .cmp_we(cmp_we), .cmp_wdata(cmp_wdata),
    .psc_act(psc_act), .arr_act(arr_act), .arr_nxt(arr_nxt), .cmp_act(cmp_act)
  );

  timer_count_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_s), .tick(tick), .restart(restart),
    .dir_wr(dir_wr), .dir_wval(cfg_dir), .align(align_q),
    .arr_act(arr_act), .arr_nxt(arr_nxt), .cmp_act(cmp_act),
    .count(count), .dir(cnt_dir), .wrap(wrap), .cmp_flag(cmp_flag)
  );

  assign cnt_en    = en_q;
  assign cnt_align = align_q;
  assign upd_req   = req_q;

  // R7: a running edge-aligned counter keeps its alignment
  a_r7_align_lock: assert property (@(posedge clk) disable iff (!rst_s)
    (en_q && align_q == ALN_EDGE) |=> (align_q == ALN_EDGE));

  // R8: single-pulse mode drops the enable after an update event
  a_r8_onepulse_stop: assert property (@(posedge clk) disable iff (!rst_s)
    (op_q && evt) |=> !en_q);

  // R9: wrap-only source filters strobe-driven requests
  a_r9_src_filter: assert property (@(posedge clk) disable iff (!rst_s)
    (src_q && !wrap) |=> !upd_req);

  // R10: update disable silences the request
  a_r10_no_req: assert property (@(posedge clk) disable iff (!rst_s)
    off_q |=> !upd_req);
endmodule

// File: tb/updown_timer_test.sv
module updown_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 8;
  localparam int PW = 4;

  logic clk, rst_n;
  logic cfg_we, cfg_en, cfg_dir, cfg_onepulse, cfg_src_ovf_only, cfg_upd_off;
  logic [1:0] cfg_align;
  logic psc_we, arr_we, cmp_we, sw_update, slv_update, slv_enable;
  logic [PW-1:0] psc_wdata;
  logic [CW-1:0] arr_wdata, cmp_wdata;
  logic cnt_en, cnt_dir, upd_req, cmp_flag;
  logic [1:0] cnt_align;
  logic [CW-1:0] count;

  int nchk = 0, nfail = 0;
  string cur_req = "R1";

  // reference model state
  int m_cnt, m_dir, m_en, m_align, m_ops, m_src, m_off, m_req, m_flag;
  int m_psc_pre, m_psc_act, m_pcnt, m_arr_pre, m_arr_act, m_cmp_pre, m_cmp_act;

  updown_timer #(.CNT_W(CW), .PSC_W(PW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_en(cfg_en), .cfg_dir(cfg_dir),
    .cfg_onepulse(cfg_onepulse), .cfg_src_ovf_only(cfg_src_ovf_only),
    .cfg_upd_off(cfg_upd_off), .cfg_align(cfg_align),
    .psc_we(psc_we), .psc_wdata(psc_wdata), .arr_we(arr_we), .arr_wdata(arr_wdata),
    .cmp_we(cmp_we), .cmp_wdata(cmp_wdata), .sw_update(sw_update),
    .slv_update(slv_update), .slv_enable(slv_enable),
    .cnt_en(cnt_en), .cnt_dir(cnt_dir), .cnt_align(cnt_align), .count(count),
    .upd_req(upd_req), .cmp_flag(cmp_flag)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string what, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", cur_req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_cnt = 0; m_dir = 0; m_en = 0; m_align = 0; m_ops = 0; m_src = 0; m_off = 0;
    m_req = 0; m_flag = 0; m_psc_pre = 0; m_psc_act = 0; m_pcnt = 0;
    m_arr_pre = 255; m_arr_act = 255; m_cmp_pre = 0; m_cmp_act = 0;
  endtask

  task automatic model_step();
    bit rs, tk, ctr, wr, ev, mv_dn, ok;
    int nc, nd, na, ne, arr_new;
    rs  = sw_update || slv_update;
    tk  = (m_en != 0) && !rs && (m_pcnt >= m_psc_act);
    ctr = (m_align != 0);
    if (m_dir == 0)  wr = tk && (m_cnt >= m_arr_act);
    else if (ctr)    wr = tk && (m_cnt <= 1);
    else             wr = tk && (m_cnt == 0);
    ev = (m_off == 0) && (wr || rs);
    arr_new = ev ? m_arr_pre : m_arr_act;
    nc = m_cnt; nd = m_dir;
    if (rs) nc = (m_dir != 0) ? arr_new : 0;
    else if (tk) begin
      if (m_dir == 0) begin
        if (!wr) nc = m_cnt + 1;
        else if (!ctr) nc = 0;
        else nc = (m_arr_act > 0) ? m_arr_act - 1 : 0;
      end else begin
        if (!wr) nc = m_cnt - 1;
        else nc = ctr ? 0 : arr_new;
      end
      if (ctr && wr) nd = 1 - m_dir;
    end
    mv_dn = ctr ? ((m_dir != 0) || wr) : (m_dir != 0);
    na = m_align;
    if (cfg_we) begin
      if (!(m_en != 0 && m_align == 0 && cfg_align != 0)) na = cfg_align;
      if (na == 0) nd = cfg_dir;
    end
    case (m_align)
      1: ok = mv_dn;
      2: ok = !mv_dn;
      default: ok = 1;
    endcase
    m_flag = (tk && ok && nc == m_cmp_act) ? 1 : 0;
    m_req  = (ev && (m_src == 0 || wr)) ? 1 : 0;
    if (rs) m_pcnt = 0;
    else if (m_en != 0) m_pcnt = tk ? 0 : m_pcnt + 1;
    if (ev) begin
      m_psc_act = m_psc_pre; m_arr_act = m_arr_pre; m_cmp_act = m_cmp_pre;
    end
    if (psc_we) m_psc_pre = psc_wdata;
    if (arr_we) m_arr_pre = arr_wdata;
    if (cmp_we) m_cmp_pre = cmp_wdata;
    ne = m_en;
    if (cfg_we) begin
      ne = cfg_en; m_ops = cfg_onepulse; m_src = cfg_src_ovf_only; m_off = cfg_upd_off;
    end
    if (slv_enable) ne = 1;
    if (m_ops != 0 && ev) ne = 0;
    m_en = ne; m_align = na; m_cnt = nc; m_dir = nd;
  endtask

  task automatic clear_inputs();
    cfg_we = 0; cfg_en = 0; cfg_dir = 0; cfg_onepulse = 0; cfg_src_ovf_only = 0;
    cfg_upd_off = 0; cfg_align = 0; psc_we = 0; arr_we = 0; cmp_we = 0;
    psc_wdata = 0; arr_wdata = 0; cmp_wdata = 0;
    sw_update = 0; slv_update = 0; slv_enable = 0;
  endtask

  // one clock: compare at the falling edge, step model, let the edge happen
  task automatic cyc();
    @(negedge clk);
    chk("count", int'(count), m_cnt);
    chk("dir", int'(cnt_dir), m_dir);
    chk("en", int'(cnt_en), m_en);
    chk("align", int'(cnt_align), m_align);
    chk("upd_req", int'(upd_req), m_req);
    chk("cmp_flag", int'(cmp_flag), m_flag);
    model_step();
    @(posedge clk);
    #1 clear_inputs();
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic cfg(int en, int dir, int op, int src, int off, int al);
    cfg_we = 1; cfg_en = en[0]; cfg_dir = dir[0]; cfg_onepulse = op[0];
    cfg_src_ovf_only = src[0]; cfg_upd_off = off[0]; cfg_align = al[1:0];
    cyc();
  endtask

  task automatic preload(int p, int a, int c);
    psc_we = 1; psc_wdata = p[PW-1:0];
    arr_we = 1; arr_wdata = a[CW-1:0];
    cmp_we = 1; cmp_wdata = c[CW-1:0];
    cyc();
  endtask

  task automatic sw_upd();
    sw_update = 1;
    cyc();
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", nchk - nfail, nchk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nfail++; nchk++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    clear_inputs();
    model_reset();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (4) @(posedge clk);
    #1;
    // R1: reset state
    cur_req = "R1";
    chk("count", int'(count), 0);
    chk("en", int'(cnt_en), 0);
    chk("dir", int'(cnt_dir), 0);
    chk("align", int'(cnt_align), 0);
    chk("upd_req", int'(upd_req), 0);
    chk("cmp_flag", int'(cmp_flag), 0);
    run(2);

    // R11: preload writes stay hidden until an update
    cur_req = "R11";
    preload(0, 3, 2);
    run(2);
    sw_upd();
    run(1);

    // R3: edge up wraps at the limit
    cur_req = "R3";
    cfg(1, 0, 0, 0, 0, 0);
    run(14);

    // R2: prescaler divide by three, then hold while disabled
    cur_req = "R2";
    preload(2, 3, 2);
    sw_upd();
    run(16);
    cfg(0, 0, 0, 0, 0, 0);
    run(6);

    // R4: edge down reloads the limit
    cur_req = "R4";
    preload(0, 3, 1);
    cfg(1, 1, 0, 0, 0, 0);
    run(4);
    cur_req = "R11";
    sw_upd();
    cur_req = "R4";
    run(12);
    cfg(0, 0, 0, 0, 0, 0);

    // R5: center-aligned sequence, software direction ignored
    cur_req = "R5";
    preload(0, 4, 2);
    sw_upd();
    cfg(0, 0, 0, 0, 0, 1);
    cfg(1, 0, 0, 0, 0, 1);
    run(10);
    cfg(1, 1, 0, 0, 0, 1);
    cfg(1, 0, 0, 0, 0, 1);
    run(20);

    // R6: compare flag gating per center mode
    cur_req = "R6";
    cfg(0, 0, 0, 0, 0, 2);
    cfg(1, 0, 0, 0, 0, 2);
    run(20);
    cfg(0, 0, 0, 0, 0, 3);
    cfg(1, 0, 0, 0, 0, 3);
    run(20);
    cfg(0, 0, 0, 0, 0, 0);
    sw_upd();

    // R7: alignment locked while running edge-aligned
    cur_req = "R7";
    cfg(1, 0, 0, 0, 0, 0);
    run(3);
    cfg(1, 0, 0, 0, 0, 2);
    chk("align locked", int'(cnt_align), 0);
    run(4);

    // R9: wrap-only request source
    cur_req = "R9";
    cfg(1, 0, 0, 1, 0, 0);
    sw_upd();
    run(10);
    slv_update = 1;
    cyc();
    run(3);

    // R10: update disable keeps shadows, still restarts
    cur_req = "R10";
    cfg(1, 0, 0, 0, 1, 0);
    preload(0, 6, 5);
    run(10);
    sw_upd();
    run(6);
    cfg(1, 0, 0, 0, 0, 0);
    sw_upd();
    run(9);

    // R8: single pulse stops at the next update event
    cur_req = "R8";
    preload(0, 3, 2);
    cfg(0, 0, 0, 0, 0, 0);
    sw_upd();
    cfg(1, 0, 1, 0, 0, 0);
    run(10);
    chk("stopped en", int'(cnt_en), 0);
    run(3);

    // R12: slave enable and slave update
    cur_req = "R12";
    cfg(0, 0, 0, 0, 0, 0);
    slv_enable = 1;
    cyc();
    run(6);
    slv_update = 1;
    cyc();
    run(6);

    summary();
    $finish;
  end
endmodule